// File: doc/BRIEF.md
# Stream Lane Complexity Up-Converter

This block sits between a multi-lane stream source that states which lanes hold data in compact form and a sink that wants one flag per lane. The source marks the occupied lanes of each transfer with a first-lane index and a final-lane index, or with a lane mask at the highest input level. It also sends one set of sequence-end bits and an empty-sequence flag for the whole transfer. The converter turns the two indices into a per-lane strobe. It then moves the sequence-end bits and the empty flag onto individual lanes, which is the form a sink accepting the richest packing freedom expects.

The input level is a parameter. At level 1 the data is packed from lane 0 upward, so the first-lane index is not used. At level 5 both indices are honoured. At level 6 the source already supplies a lane mask. Element data and the user field pass through untouched. Valid/ready flow control passes straight through. An optional output register stage can be enabled; it keeps full throughput and loses nothing under backpressure.

Top module: `lane_cplx_upconv`

## Requirements
- R1: At input level 5, for a non-empty transfer, output strobe bit i is 1 exactly when first-lane index ≤ i ≤ final-lane index. Lane 0 is bit 0.
- R2: At input level 1, the first-lane index has no effect; the strobe covers lanes 0 through the final-lane index.
- R3: A transfer with the empty flag set gives an all-zero strobe. Its per-lane empty flag is 1 on lane 0 only, and its sequence-end bits appear on lane 0 only.
- R4: For a non-empty transfer, the D sequence-end bits appear unchanged in the field of the lane named by the final-lane index. Every other lane's field is zero. Lane i's field is bits [i*D +: D].
- R5: For a non-empty transfer, every per-lane empty flag is 0.
- R6: Element data and the user field leave the block unchanged.
- R7: With the register stage, the block comes out of reset with no output pending. Transfers leave in arrival order with none lost or duplicated. An output held by low ready keeps valid high and all output fields stable.
- R8: With the register stage, input ready is high in every cycle in which output ready is high, so one transfer per cycle is sustained.
- R9: Without the register stage, output valid equals input valid and input ready equals output ready in the same cycle.
- R10: At input level 6, the output strobe equals the input lane mask for non-empty transfers; the indices do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input transfer valid |
| in_ready | output | 1 | Input transfer accepted |
| in_data | input | N*E | Element lanes, lane i at [i*E +: E] |
| in_stai | input | IW | First occupied lane index (level 5) |
| in_endi | input | IW | Final occupied lane index |
| in_strb | input | N | Lane mask (level 6) |
| in_last | input | D | Per-transfer sequence-end bits |
| in_empty | input | 1 | Transfer carries an empty sequence |
| in_user | input | U | User bits |
| out_valid | output | 1 | Output transfer valid |
| out_ready | input | 1 | Output transfer accepted |
| out_data | output | N*E | Element lanes |
| out_strb | output | N | Per-lane strobe |
| out_last | output | N*D | Per-lane sequence-end bits |
| out_empty | output | N | Per-lane empty flags |
| out_user | output | U | User bits |

## Verification
The bench builds three copies with N=4, E=8, D=2 and U=2. The main copy takes level-5 input with the register stage. It is driven through random backpressure phases and full-rate phases, which exposes ordering, stall stability and sustained rate. A level-1 copy and a level-6 copy have no register stage and share the same inputs. On these, random first-lane indices and random lane masks show directly whether the index or the mask is ignored or honoured, and show the same-cycle pass-through of the handshake. Four lanes make the edge lanes 0 and 3, single-lane runs and empty transfers common under random stimulus.

// File: rtl/lcu_pkg.sv
package lcu_pkg;
   // index width for an N-lane stream, never below one bit
   function automatic int unsigned lane_idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/lcu_strobe_gen.sv
module lcu_strobe_gen #(
   parameter int unsigned N    = 4,
   parameter int unsigned IW   = 2,
   parameter int unsigned CPLX = 5
) (
   input  logic [IW-1:0] stai,
   input  logic [IW-1:0] endi,
   input  logic [N-1:0]  mask_in,
   input  logic          empty,
   output logic [N-1:0]  strb
);
   logic [IW-1:0] lo_idx;
   logic [N-1:0]  range_v;

   // level 1 packs from lane 0; the first-lane index is disregarded
   assign lo_idx = (CPLX >= 5) ? stai : '0;

   for (genvar i = 0; i < N; i++) begin : g_lane
      localparam logic [IW-1:0] LANE = IW'(i);
      assign range_v[i] = (lo_idx <= LANE) && (LANE <= endi);
   end

   assign strb = (CPLX >= 6) ? (mask_in & ~{N{empty}}) : (range_v & ~{N{empty}});
endmodule

// File: rtl/lcu_dim_spread.sv
module lcu_dim_spread #(
   parameter int unsigned N  = 4,
   parameter int unsigned D  = 2,
   parameter int unsigned IW = 2
) (
   input  logic [IW-1:0]  endi,
   input  logic [D-1:0]   last_in,
   input  logic           empty,
   output logic [N*D-1:0] last_out,
   output logic [N-1:0]   empty_out
);
   for (genvar i = 0; i < N; i++) begin : g_lane
      localparam logic [IW-1:0] LANE = IW'(i);
      logic hit;
      // an empty sequence is reported on lane 0, a filled one at its final lane
      assign hit                  = empty ? (i == 0) : (endi == LANE);
      assign last_out[i*D +: D]   = hit ? last_in : '0;
      assign empty_out[i]         = empty && (i == 0);
   end
endmodule

// File: rtl/lcu_out_slice.sv
module lcu_out_slice #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_pay,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_pay
);
   logic         vld_q;
   logic [W-1:0] pay_q;

   assign in_ready  = !vld_q || out_ready;
   assign out_valid = vld_q;
   assign out_pay   = pay_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         pay_q <= '0;
      end else if (in_ready) begin
         vld_q <= in_valid;
         if (in_valid) pay_q <= in_pay;
      end
   end

   AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pay))); // R7
endmodule

// File: rtl/lane_cplx_upconv.sv
module lane_cplx_upconv #(
   parameter int unsigned N       = 4,
   parameter int unsigned E       = 8,
   parameter int unsigned D       = 2,
   parameter int unsigned U       = 2,
   parameter int unsigned IN_CPLX = 5,
   parameter bit          REG_OUT = 1'b1,
   parameter int unsigned IW      = lcu_pkg::lane_idx_w(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [N*E-1:0] in_data,
   input  logic [IW-1:0]  in_stai,
   input  logic [IW-1:0]  in_endi,
   input  logic [N-1:0]   in_strb,
   input  logic [D-1:0]   in_last,
   input  logic           in_empty,
   input  logic [U-1:0]   in_user,
   output logic           out_valid,
   input  logic           out_ready,
   output logic [N*E-1:0] out_data,
   output logic [N-1:0]   out_strb,
   output logic [N*D-1:0] out_last,
   output logic [N-1:0]   out_empty,
   output logic [U-1:0]   out_user
);
   localparam int unsigned PW = N*E + N + N*D + N + U;

   if (!(IN_CPLX == 1 || IN_CPLX == 5 || IN_CPLX == 6)) begin : g_bad_cplx
      $error("lane_cplx_upconv: IN_CPLX must be 1, 5 or 6");
   end
   if (N < 1 || E < 1 || D < 1 || U < 1) begin : g_bad_width
      $error("lane_cplx_upconv: N, E, D and U must be at least 1");
   end
   if (IW < lcu_pkg::lane_idx_w(N)) begin : g_bad_iw
      $error("lane_cplx_upconv: IW too narrow for N lanes");
   end

   logic [N-1:0]   cv_strb;
   logic [N*D-1:0] cv_last;
   logic [N-1:0]   cv_empty;
   logic [PW-1:0]  cv_pay;
   logic [PW-1:0]  o_pay;

   lcu_strobe_gen #(.N(N), .IW(IW), .CPLX(IN_CPLX)) u_strb (
      .stai    (in_stai),
      .endi    (in_endi),
      .mask_in (in_strb),
      .empty   (in_empty),
      .strb    (cv_strb)
   );

   lcu_dim_spread #(.N(N), .D(D), .IW(IW)) u_dim (
      .endi      (in_endi),
      .last_in   (in_last),
      .empty     (in_empty),
      .last_out  (cv_last),
      .empty_out (cv_empty)
   );

   assign cv_pay = {in_data, cv_strb, cv_last, cv_empty, in_user};

   if (REG_OUT) begin : g_reg
      lcu_out_slice #(.W(PW)) u_slice (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (in_valid),
         .in_ready  (in_ready),
         .in_pay    (cv_pay),
         .out_valid (out_valid),
         .out_ready (out_ready),
         .out_pay   (o_pay)
      );
   end else begin : g_comb
      assign out_valid = in_valid;
      assign in_ready  = out_ready;
      assign o_pay     = cv_pay;
   end

   assign {out_data, out_strb, out_last, out_empty, out_user} = o_pay;

   // per-lane flag: any sequence-end bit present on that lane
   logic [N-1:0] lane_has_last;
   for (genvar i = 0; i < N; i++) begin : g_chk
      assign lane_has_last[i] = |out_last[i*D +: D];
   end

   AST_EMPTY_LANE0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_empty >> 1) == '0)); // R3
   AST_EMPTY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_empty[0]) |-> (out_strb == '0)); // R3
   AST_LAST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(lane_has_last) <= 1)); // R4
   AST_NONEMPTY_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_empty[0]) |-> (out_empty == '0)); // R5
endmodule

// File: tb/test_lane_cplx_upconv.sv
module test_lane_cplx_upconv;
   localparam int N = 4, E = 8, D = 2, U = 2, IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk; // 50 MHz

   logic           in_valid = 0, in_empty = 0, out_ready = 0;
   logic [N*E-1:0] in_data = '0;
   logic [IW-1:0]  in_stai = '0, in_endi = '0;
   logic [N-1:0]   in_strb = '0;
   logic [D-1:0]   in_last = '0;
   logic [U-1:0]   in_user = '0;

   logic m_in_ready, m_out_valid;
   logic [N*E-1:0] m_data; logic [N-1:0] m_strb, m_empty; logic [N*D-1:0] m_last; logic [U-1:0] m_user;
   logic a_in_ready, a_out_valid;
   logic [N*E-1:0] a_data; logic [N-1:0] a_strb, a_empty; logic [N*D-1:0] a_last; logic [U-1:0] a_user;
   logic b_in_ready, b_out_valid;
   logic [N*E-1:0] b_data; logic [N-1:0] b_strb, b_empty; logic [N*D-1:0] b_last; logic [U-1:0] b_user;

   lane_cplx_upconv #(.N(N), .E(E), .D(D), .U(U), .IN_CPLX(5), .REG_OUT(1'b1)) i_lane_cplx_upconv (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(m_in_ready), .in_data(in_data),
      .in_stai(in_stai), .in_endi(in_endi), .in_strb(in_strb), .in_last(in_last), .in_empty(in_empty),
      .in_user(in_user), .out_valid(m_out_valid), .out_ready(out_ready), .out_data(m_data),
      .out_strb(m_strb), .out_last(m_last), .out_empty(m_empty), .out_user(m_user));

   lane_cplx_upconv #(.N(N), .E(E), .D(D), .U(U), .IN_CPLX(1), .REG_OUT(1'b0)) i_lane_cplx_upconv_c1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(a_in_ready), .in_data(in_data),
      .in_stai(in_stai), .in_endi(in_endi), .in_strb(in_strb), .in_last(in_last), .in_empty(in_empty),
      .in_user(in_user), .out_valid(a_out_valid), .out_ready(1'b1), .out_data(a_data),
      .out_strb(a_strb), .out_last(a_last), .out_empty(a_empty), .out_user(a_user));

   lane_cplx_upconv #(.N(N), .E(E), .D(D), .U(U), .IN_CPLX(6), .REG_OUT(1'b0)) i_lane_cplx_upconv_c6 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(b_in_ready), .in_data(in_data),
      .in_stai(in_stai), .in_endi(in_endi), .in_strb(in_strb), .in_last(in_last), .in_empty(in_empty),
      .in_user(in_user), .out_valid(b_out_valid), .out_ready(out_ready), .out_data(b_data),
      .out_strb(b_strb), .out_last(b_last), .out_empty(b_empty), .out_user(b_user));

   int nchk = 0, nerr = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [N-1:0] f_strb(input int cplx, input logic [IW-1:0] s, input logic [IW-1:0] e,
                                          input logic emp, input logic [N-1:0] mk);
      logic [N-1:0] r = '0;
      int lo = (cplx >= 5) ? int'(s) : 0;
      if (emp) return '0;
      if (cplx >= 6) return mk;
      for (int i = 0; i < N; i++) r[i] = (i >= lo) && (i <= int'(e));
      return r;
   endfunction

   function automatic logic [N*D-1:0] f_last(input logic [IW-1:0] e, input logic [D-1:0] l, input logic emp);
      logic [N*D-1:0] r = '0;
      for (int i = 0; i < N; i++)
         if (emp ? (i == 0) : (i == int'(e))) r[i*D +: D] = l;
      return r;
   endfunction

   logic [N*E-1:0] qd[$]; logic [N-1:0] qs[$]; logic [N*D-1:0] ql[$];
   logic [N-1:0]   qe[$]; logic [U-1:0] qu[$]; logic qemp[$];
   bit accepted = 0, stall_prev = 0;
   logic [N*E+N+N*D+N+U-1:0] held;

   // evaluate the cycle mid-way through the low phase, before the next rising edge
   task automatic tick();
      #5;
      if (in_valid && m_in_ready) begin
         qd.push_back(in_data); qs.push_back(f_strb(5, in_stai, in_endi, in_empty, in_strb));
         ql.push_back(f_last(in_endi, in_last, in_empty)); qe.push_back(in_empty ? N'(1) : '0);
         qu.push_back(in_user); qemp.push_back(in_empty);
         accepted = 1;
      end else accepted = 0;
      if (stall_prev) begin
         chk("R7 stalled valid held", m_out_valid, 1);
         chk("R7 stalled fields stable", {m_data, m_strb, m_last, m_empty, m_user}, held);
      end
      stall_prev = m_out_valid && !out_ready;
      held = {m_data, m_strb, m_last, m_empty, m_user};
      if (out_ready) chk("R8 ready at full rate", m_in_ready, 1);
      if (m_out_valid && out_ready) begin
         if (qd.size() == 0) chk("R7 unexpected output", 1, 0);
         else begin
            logic e0 = qemp.pop_front();
            chk(e0 ? "R3 strobe on empty" : "R1 strobe range", m_strb, qs.pop_front());
            chk(e0 ? "R3 last on empty" : "R4 last placement", m_last, ql.pop_front());
            chk(e0 ? "R3 empty flags" : "R5 empty flags", m_empty, qe.pop_front());
            chk("R6 data", m_data, qd.pop_front());
            chk("R6 user", m_user, qu.pop_front());
         end
      end
      if (in_valid) begin
         chk("R9 comb valid", a_out_valid, 1);
         chk("R9 comb ready", b_in_ready, out_ready);
         chk("R2 level-1 strobe", a_strb, f_strb(1, in_stai, in_endi, in_empty, in_strb));
         chk("R10 level-6 strobe", b_strb, f_strb(6, in_stai, in_endi, in_empty, in_strb));
         chk("R4 level-1 last", a_last, f_last(in_endi, in_last, in_empty));
         chk("R6 level-6 data", b_data, in_data);
      end else chk("R9 comb idle", a_out_valid, 0);
      @(negedge clk);
   endtask

   task automatic drive(input logic [IW-1:0] s, input logic [IW-1:0] e, input logic emp);
      in_valid = 1; in_stai = s; in_endi = e; in_empty = emp;
      in_data = {$urandom, $urandom}; in_user = U'($urandom);
      in_last = D'($urandom | 1); in_strb = N'($urandom);
      out_ready = 1;
      tick();
      while (!accepted) tick();
      in_valid = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R7 reset no output", m_out_valid, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R7 reset ready", m_in_ready, 1);
      // directed corners
      drive(0, 0, 0); drive(0, 3, 0); drive(3, 3, 0); drive(1, 2, 0);
      drive(2, 1, 1); drive(3, 0, 0); drive(0, 3, 1);
      repeat (3) begin out_ready = 1; tick(); end
      // random with phases of backpressure and full rate
      void'($urandom(32'h5eed_1234));
      for (int c = 0; c < 3000; c++) begin
         bit full = ((c / 200) % 2) == 1;
         if (!(in_valid && !accepted)) begin
            logic [IW-1:0] e = IW'($urandom % N);
            in_valid = ($urandom % 4) != 0 || full;
            in_endi  = e;
            in_stai  = IW'($urandom % (int'(e) + 1));
            in_empty = ($urandom % 6) == 0;
            in_data  = {$urandom, $urandom};
            in_strb  = N'($urandom);
            in_last  = D'($urandom);
            in_user  = U'($urandom);
         end
         out_ready = full ? 1'b1 : (($urandom % 3) != 0);
         tick();
      end
      in_valid = 0; out_ready = 1;
      repeat (4) tick();
      chk("R7 nothing lost", qd.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule